// File: doc/BRIEF.md
# Multicast Configuration Write Distributor

This block sits between a host that writes decoder configuration and an array of decoder cores, each owning a small configuration memory. Every host write carries a delivery class. The class says whether the word goes to a single core, to every core of one decoder component, or to every core in the array. In one cycle the block turns this class and a target field into a vector of per-core write enables. All selected cores then see the same word address and data on a shared write bus.

The configuration space is split into three fixed word regions, and each delivery class may only write its own region. The lowest words hold per-core values such as the core identity and the tail-handling flag. The middle words hold values shared by the cores of one component. The top words hold values common to every core. Because of this split, one broadcast and one multicast per component cover most of a reconfiguration, and only the small per-core part needs individual writes. A write whose class does not match its address region is dropped, and the block pulses an error flag instead. A reserved class, or a target that selects no core, is handled the same way. The host handshake takes one transaction per cycle, and the write reaches the cores one cycle after it is accepted.

Top module: `cfgw_fanout`

## Requirements
- R1: While `rst_n` is low, `core_we` is all zero, `cfg_err` is low and `req_ready` is low.
- R2: From the first rising edge with `rst_n` high, `req_ready` is high on every cycle, so one transaction can be accepted on every cycle.
- R3: A transaction accepted with class `2'b00` (single core) and word address 0 or 1 sets exactly bit `req_target` of `core_we` in the following cycle. In that same cycle `core_addr` and `core_data` carry the transaction's address and data.
- R4: A transaction accepted with class `2'b01` (component) and word address 2 to 6 sets, in the following cycle, the enables of every core whose index divided by 4 equals bit 0 of `req_target`. Cores 0–3 form component 0 and cores 4–7 form component 1. The upper target bits are ignored.
- R5: A transaction accepted with class `2'b10` (all cores) and word address 7 to 10 sets every bit of `core_we` in the following cycle, with `core_addr` and `core_data` carrying the transaction's address and data.
- R6: A transaction accepted with a valid class but an address in a different class's region writes no core. `cfg_err` is high for exactly the following cycle.
- R7: A transaction accepted with the reserved class `2'b11` writes no core, at any address, and pulses `cfg_err` in the following cycle.
- R8: Word addresses 11 to 15 belong to no region. A transaction to any of them writes no core, in any class, and pulses `cfg_err` in the following cycle.
- R9: A cycle with `req_valid` low gives, in the following cycle, `core_we` all zero and `cfg_err` low, whatever the other request inputs hold.
- R10: Transactions accepted on consecutive cycles each produce their own write or error in the cycle after their acceptance, with no gap and no merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host presents a transaction |
| req_ready | output | 1 | Block accepts a transaction this cycle |
| req_mode | input | 2 | Delivery class: 00 single core, 01 component, 10 all cores, 11 reserved |
| req_target | input | 3 | Core index (single core) or component index in its low bit (component) |
| req_addr | input | 4 | Configuration word address |
| req_data | input | 26 | Configuration word |
| core_we | output | 8 | Per-core write enable, one bit per core |
| core_addr | output | 4 | Shared word address for the enabled cores |
| core_data | output | 26 | Shared data word for the enabled cores |
| cfg_err | output | 1 | One-cycle pulse for a dropped transaction |

## Verification
The bench builds the block with its default values: eight cores in two components of four, a 4-bit word address and 26-bit data. With these values every combination of class, target and address fits in 512 transactions, so all of them are driven back to back. This covers each region boundary, the reserved class, the addresses above the top region, and a component index taken from the target's low bit when the upper bits are set. Idle cycles with arbitrary inputs are mixed in to show that an absent request has no effect.

// File: rtl/cfgw_pkg.sv
`timescale 1ns/1ps
package cfgw_pkg;

   // Delivery class carried by each host transaction
   typedef enum logic [1:0] {
      DM_CORE = 2'b00,
      DM_COMP = 2'b01,
      DM_ALL  = 2'b10,
      DM_RSV  = 2'b11
   } dmode_e;

endpackage

// File: rtl/cfgw_region_check.sv
`timescale 1ns/1ps
module cfgw_region_check
   import cfgw_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int CORE_LO = 0,
   parameter int CORE_HI = 1,
   parameter int COMP_LO = 2,
   parameter int COMP_HI = 6,
   parameter int ALL_LO  = 7,
   parameter int ALL_HI  = 10
) (
   input  dmode_e              mode,
   input  logic [ADDR_W-1:0]   addr,
   output logic                in_region
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time checks on the region layout
   if (!(CORE_LO <= CORE_HI && CORE_HI < COMP_LO && COMP_LO <= COMP_HI &&
         COMP_HI < ALL_LO && ALL_LO <= ALL_HI)) begin : g_bad_order
      $error("cfgw_region_check: regions must be ascending and disjoint");
   end
   if (ALL_HI >= ADDR_SPAN) begin : g_bad_span
      $error("cfgw_region_check: top region exceeds the address space");
   end

   logic [ADDR_W:0] a_ext;
   logic            hit_core;
   logic            hit_comp;
   logic            hit_all;

   assign a_ext = {1'b0, addr};

   // A region starting at word 0 needs no lower compare
   if (CORE_LO == 0) begin : g_core_from_zero
      assign hit_core = (a_ext <= (ADDR_W+1)'(CORE_HI));
   end else begin : g_core_window
      assign hit_core = (a_ext >= (ADDR_W+1)'(CORE_LO)) &&
                        (a_ext <= (ADDR_W+1)'(CORE_HI));
   end

   assign hit_comp = (a_ext >= (ADDR_W+1)'(COMP_LO)) &&
                     (a_ext <= (ADDR_W+1)'(COMP_HI));

   // A top region that ends at the last word needs no upper compare
   if (ALL_HI == ADDR_SPAN - 1) begin : g_all_to_top
      assign hit_all = (a_ext >= (ADDR_W+1)'(ALL_LO));
   end else begin : g_all_window
      assign hit_all = (a_ext >= (ADDR_W+1)'(ALL_LO)) &&
                       (a_ext <= (ADDR_W+1)'(ALL_HI));
   end

   always_comb begin
      unique case (mode)
         DM_CORE: in_region = hit_core;
         DM_COMP: in_region = hit_comp;
         DM_ALL:  in_region = hit_all;
         default: in_region = 1'b0;
      endcase
   end

   // R8 / R6: regions are disjoint, so at most one hit at a time
   always_comb begin
      region_disjoint_chk: assert ($countones({hit_core, hit_comp, hit_all}) <= 1)
         else $error("cfgw_region_check: overlapping region hit");
   end

endmodule

// File: rtl/cfgw_core_mask.sv
`timescale 1ns/1ps
module cfgw_core_mask
   import cfgw_pkg::*;
#(
   parameter int NUM_CORES  = 8,
   parameter int NUM_GROUPS = 2,
   parameter int TGT_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  dmode_e              mode,
   input  logic [TGT_W-1:0]    target,
   output logic [NUM_CORES-1:0] mask
);

   localparam int PER_GROUP = NUM_CORES / NUM_GROUPS;
   localparam int GID_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

   if (NUM_GROUPS < 1 || NUM_CORES % NUM_GROUPS != 0) begin : g_bad_split
      $error("cfgw_core_mask: cores must divide evenly into groups");
   end
   if (GID_W > TGT_W) begin : g_bad_gid
      $error("cfgw_core_mask: group index wider than target field");
   end

   logic [GID_W-1:0] gid;
   assign gid = target[GID_W-1:0];

   // One selector per core; group membership is fixed by index
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      localparam int MY_GROUP = c / PER_GROUP;
      logic sel_one;
      logic sel_grp;
      assign sel_one = (target == TGT_W'(c));
      if (NUM_GROUPS == 1) begin : g_single_group
         assign sel_grp = 1'b1;
      end else begin : g_multi_group
         assign sel_grp = (gid == GID_W'(MY_GROUP));
      end
      always_comb begin
         unique case (mode)
            DM_CORE: mask[c] = sel_one;
            DM_COMP: mask[c] = sel_grp;
            DM_ALL:  mask[c] = 1'b1;
            default: mask[c] = 1'b0;
         endcase
      end
   end

   // R3: a single-core selection never names more than one core
   always_comb begin
      if (mode == DM_CORE) begin
         single_sel_chk: assert ($countones(mask) <= 1)
            else $error("cfgw_core_mask: single-core mode selected several cores");
      end
   end

endmodule

// File: rtl/cfgw_write_stage.sv
`timescale 1ns/1ps
module cfgw_write_stage #(
   parameter int NUM_CORES = 8,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 26
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 legal,
   input  logic [NUM_CORES-1:0] mask,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    data,
   output logic                 ready,
   output logic [NUM_CORES-1:0] we,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [DATA_W-1:0]    wr_data,
   output logic                 err
);

   logic deliver;
   assign deliver = take && legal && (|mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready <= 1'b0;
         we    <= '0;
         err   <= 1'b0;
      end else begin
         ready <= 1'b1;
         we    <= deliver ? mask : '0;
         err   <= take && !deliver;
      end
   end

   // Address and data only move on a delivered write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_addr <= '0;
         wr_data <= '0;
      end else if (deliver) begin
         wr_addr <= addr;
         wr_data <= data;
      end
   end

   // R6
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (we == '0))
      else $error("cfgw_write_stage: error and write in the same cycle");

   // R2
   ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ready)
      else $error("cfgw_write_stage: ready low after reset");

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> (we == '0) && !err)
      else $error("cfgw_write_stage: output without an accepted request");

endmodule

// File: rtl/cfgw_fanout.sv
`timescale 1ns/1ps
module cfgw_fanout
   import cfgw_pkg::*;
#(
   parameter int NUM_CORES  = 8,
   parameter int NUM_GROUPS = 2,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 26,
   parameter int CORE_LO    = 0,
   parameter int CORE_HI    = 1,
   parameter int COMP_LO    = 2,
   parameter int COMP_HI    = 6,
   parameter int ALL_LO     = 7,
   parameter int ALL_HI     = 10,
   parameter int TGT_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [1:0]           req_mode,
   input  logic [TGT_W-1:0]     req_target,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_data,
   output logic [NUM_CORES-1:0] core_we,
   output logic [ADDR_W-1:0]    core_addr,
   output logic [DATA_W-1:0]    core_data,
   output logic                 cfg_err
);

   localparam int PER_GROUP = NUM_CORES / NUM_GROUPS;

   if (NUM_CORES < 2) begin : g_bad_cores
      $error("cfgw_fanout: at least two cores are required");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("cfgw_fanout: data width must be positive");
   end

   dmode_e               mode;
   logic                 take;
   logic                 legal;
   logic [NUM_CORES-1:0] mask;

   assign mode = dmode_e'(req_mode);
   assign take = req_valid && req_ready;

   cfgw_region_check #(
      .ADDR_W  (ADDR_W),
      .CORE_LO (CORE_LO),
      .CORE_HI (CORE_HI),
      .COMP_LO (COMP_LO),
      .COMP_HI (COMP_HI),
      .ALL_LO  (ALL_LO),
      .ALL_HI  (ALL_HI)
   ) u_region (
      .mode      (mode),
      .addr      (req_addr),
      .in_region (legal)
   );

   cfgw_core_mask #(
      .NUM_CORES  (NUM_CORES),
      .NUM_GROUPS (NUM_GROUPS),
      .TGT_W      (TGT_W)
   ) u_mask (
      .mode   (mode),
      .target (req_target),
      .mask   (mask)
   );

   cfgw_write_stage #(
      .NUM_CORES (NUM_CORES),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .legal   (legal),
      .mask    (mask),
      .addr    (req_addr),
      .data    (req_data),
      .ready   (req_ready),
      .we      (core_we),
      .wr_addr (core_addr),
      .wr_data (core_data),
      .err     (cfg_err)
   );

   // R3
   core_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_mode == 2'b00 && {1'b0, req_addr} >= (ADDR_W+1)'(CORE_LO) &&
       {1'b0, req_addr} <= (ADDR_W+1)'(CORE_HI) &&
       {1'b0, req_target} < (TGT_W+1)'(NUM_CORES))
      |=> ($countones(core_we) == 1) && (core_addr == $past(req_addr)))
      else $error("cfgw_fanout: single-core write not delivered to one core");

   // R4
   comp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_mode == 2'b01 && {1'b0, req_addr} >= (ADDR_W+1)'(COMP_LO) &&
       {1'b0, req_addr} <= (ADDR_W+1)'(COMP_HI) && NUM_GROUPS == (1 << $clog2(NUM_GROUPS)))
      |=> ($countones(core_we) == PER_GROUP))
      else $error("cfgw_fanout: component write did not reach a whole group");

   // R5
   all_cores_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_mode == 2'b10 && {1'b0, req_addr} >= (ADDR_W+1)'(ALL_LO) &&
       {1'b0, req_addr} <= (ADDR_W+1)'(ALL_HI))
      |=> (&core_we) && (core_data == $past(req_data)))
      else $error("cfgw_fanout: broadcast write missed a core");

   // R7
   rsv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_mode == 2'b11) |=> cfg_err && (core_we == '0))
      else $error("cfgw_fanout: reserved class not dropped");

   // R8
   top_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && {1'b0, req_addr} > (ADDR_W+1)'(ALL_HI)) |=> cfg_err)
      else $error("cfgw_fanout: address above all regions not flagged");

endmodule

// File: tb/cfgw_fanout_tb_top.sv
`timescale 1ns/1ps
module cfgw_fanout_tb_top;

   localparam int NC = 8;
   localparam int AW = 4;
   localparam int DW = 26;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [1:0]    req_mode;
   logic [TW-1:0] req_target;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic [NC-1:0] core_we;
   logic [AW-1:0] core_addr;
   logic [DW-1:0] core_data;
   logic          cfg_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Expected outputs for the cycle after the last drive
   logic [NC-1:0] exp_we;
   logic          exp_err;
   logic [AW-1:0] exp_addr;
   logic [DW-1:0] exp_data;
   string         exp_tag;
   bit            have_exp;

   always #2.5 clk = ~clk;

   cfgw_fanout dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_mode   (req_mode),
      .req_target (req_target),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .core_we    (core_we),
      .core_addr  (core_addr),
      .core_data  (core_data),
      .cfg_err    (cfg_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Reference model from the requirements
   task automatic predict(input bit v, input bit rdy, input logic [1:0] m,
                          input logic [TW-1:0] t, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
      int ai;
      ai = int'(a);
      exp_we  = '0;
      exp_err = 1'b0;
      if (!(v && rdy)) begin
         exp_tag = "R9";
         return;
      end
      case (m)
         2'b00: begin
            exp_tag = "R3";
            if (ai <= 1) exp_we[t] = 1'b1;
         end
         2'b01: begin
            exp_tag = "R4";
            if (ai >= 2 && ai <= 6)
               for (int c = 0; c < NC; c++)
                  if ((c / 4) == int'(t[0])) exp_we[c] = 1'b1;
         end
         2'b10: begin
            exp_tag = "R5";
            if (ai >= 7 && ai <= 10) exp_we = '1;
         end
         default: exp_tag = "R7";
      endcase
      if (exp_we == '0) begin
         exp_err = 1'b1;
         if (m != 2'b11) exp_tag = (ai >= 11) ? "R8" : "R6";
      end else begin
         exp_addr = a;
         exp_data = d;
      end
   endtask

   // One clock: compare the previous prediction, then drive the next request
   task automatic step(input bit v, input logic [1:0] m, input logic [TW-1:0] t,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      if (have_exp) begin
         check(core_we == exp_we, exp_tag, "core_we", 64'(core_we), 64'(exp_we));
         check(cfg_err == exp_err, exp_tag, "cfg_err", 64'(cfg_err), 64'(exp_err));
         if (exp_we != '0) begin
            check(core_addr == exp_addr && core_data == exp_data, exp_tag,
                  "addr/data", {30'd0, core_addr, core_data}, {30'd0, exp_addr, exp_data});
         end
         check(req_ready == 1'b1, "R2", "req_ready", 64'(req_ready), 64'd1);
      end
      req_valid  = v;
      req_mode   = m;
      req_target = t;
      req_addr   = a;
      req_data   = d;
      predict(v, req_ready, m, t, a, d);
      have_exp = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      have_exp   = 1'b0;
      rst_n      = 1'b0;
      req_valid  = 1'b0;
      req_mode   = 2'b00;
      req_target = '0;
      req_addr   = '0;
      req_data   = '0;
      repeat (3) @(negedge clk);
      // R1: reset state, with a request driven to show it is ignored
      req_valid = 1'b1;
      req_mode  = 2'b10;
      req_addr  = 4'd7;
      @(negedge clk);
      @(negedge clk);
      check(core_we == '0, "R1", "core_we", 64'(core_we), 64'd0);
      check(cfg_err == 1'b0, "R1", "cfg_err", 64'(cfg_err), 64'd0);
      check(req_ready == 1'b0, "R1", "req_ready", 64'(req_ready), 64'd0);
      req_valid = 1'b0;
      rst_n     = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R2", "req_ready", 64'(req_ready), 64'd1);

      // Idle cycles with arbitrary inputs (R9)
      step(1'b0, 2'b10, 3'd5, 4'd8, 26'h3ABCDEF);
      step(1'b0, 2'b00, 3'd2, 4'd0, 26'h0123456);

      // Exhaustive sweep, back to back (R10), all regions and targets
      for (int m = 0; m < 4; m++)
         for (int a = 0; a < 16; a++)
            for (int t = 0; t < 8; t++)
               step(1'b1, 2'(m), 3'(t), 4'(a), 26'((m * 1234567) ^ (a * 40503) ^ (t * 977) ^ 26'h2A5A5A5));

      // Mixed idle and active pattern
      for (int k = 0; k < 40; k++)
         step((k % 3) != 0, 2'(k % 4), 3'(k * 3), 4'(k % 13), 26'(k * 98765));

      step(1'b0, 2'b00, 3'd0, 4'd0, 26'd0);
      step(1'b0, 2'b00, 3'd0, 4'd0, 26'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule